// File: doc/BRIEF.md
# Programmable-Modulus Counter-Mode Keystream Stage

This block produces the counter sequence for block-cipher counter mode and combines the returned keystream with the data. It holds a 128-bit counter block that a host loads before a message starts. An external cipher core encrypts the counter value shown on `ctr_out`. When that core hands back a keystream block together with a data block, the block XORs the two into the output block. In the same cycle it advances the counter. Encryption and decryption are the same operation.

Only the low M bits of the counter form the running part. They count modulo 2^M, and the bits above them stay fixed. M is a byte-granular exponent from 8 to 128. The host reaches the counter and M through three 64-bit context slots. In standard mode these are slots 4..6. In the reduced-context mode they are slots 0..2. The current counter can be read back through the same window at any time, so a paused message can be saved and later restored.

Top module: `ctr_mod_counter`

## Requirements
- R1: After a synchronous reset, `ctr_out` is zero, `out_valid` is 0, `data_out` is zero and the effective M is 128.
- R2: One cycle after `blk_valid` is high, `out_valid` is 1 and `data_out` equals the `data_in` XOR `keystream` sampled with it. In a cycle where `blk_valid` is low, `out_valid` drops to 0 on the next edge.
- R3: Each accepted block (`blk_valid` high and no counter write in that cycle) adds one to the low M bits of `ctr_out`, visible on the next cycle.
- R4: During an increment, the bits at positions M and above are unchanged and the carry out of bit M−1 is dropped, so the low M bits wrap from all ones to zero.
- R5: M is written as bits [7:0] of the modulus slot. The legal values are 8..128 in steps of 8. Any other value, including 0, is stored as 128. Reading the modulus slot returns the effective M in bits [7:0] and zeros above.
- R6: Window offsets are as follows: offset 0 holds counter bits [127:64], offset 1 holds bits [63:0], and offset 2 holds the modulus. The window base is slot 4 when `mode_reduced` is 0 and slot 0 when it is 1.
- R7: A write to a slot outside the active window changes nothing. A read of such a slot returns zero.
- R8: `ctx_rd_data` returns, one cycle after `ctx_rd_addr` is presented, the slot contents as they stood before that edge. This holds at any time, including while blocks stream.
- R9: If a counter slot is written in the same cycle as `blk_valid`, the written half takes the host value, the other half holds, and no increment happens. The output block is still produced.
- R10: With `blk_valid` low and no write, `ctr_out` and `data_out` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_reduced | input | 1 | 1 selects the slot 0..2 window, 0 selects slots 4..6 |
| ctx_wr_en | input | 1 | Context slot write strobe |
| ctx_wr_addr | input | 3 | Slot index for the write |
| ctx_wr_data | input | 64 | Slot write data |
| ctx_rd_addr | input | 3 | Slot index for the read |
| ctx_rd_data | output | 64 | Registered slot read data |
| blk_valid | input | 1 | A keystream/data block pair is present |
| data_in | input | 128 | Input data block |
| keystream | input | 128 | Encrypted counter from the cipher core |
| data_out | output | 128 | Registered output block |
| out_valid | output | 1 | `data_out` was updated this cycle |
| ctr_out | output | 128 | Current counter block for the cipher core |

## Verification
Every legal M from 8 to 128 is tried with a counter whose low M bits are all ones over a fixed nonzero upper pattern. One step must clear exactly those bits and leave the pattern intact, and a second step must produce a one at bit 0. This separates a correct lane mask from one that is off by a byte or that lets the carry escape. Illegal exponents (0, a non-multiple of 8, above 128) followed by a full-width wrap show that they fall back to 128. XOR checks use zero, alternating and mixed patterns. Writes and reads in both window modes, including out-of-window slots and a write that collides with a block, cover the slot mapping and write priority.

// File: rtl/ctr_pkg.sv
package ctr_pkg;

  // Which context field a slot index lands on once the window base is removed
  typedef enum logic [1:0] {
    SEL_CTR_HI = 2'd0,
    SEL_CTR_LO = 2'd1,
    SEL_MOD    = 2'd2,
    SEL_NONE   = 2'd3
  } slot_sel_e;

  localparam int WINDOW_SLOTS = 3;

endpackage

// File: rtl/ctr_ctx_map.sv
module ctr_ctx_map
  import ctr_pkg::*;
#(
  parameter int ADDR_W   = 3,
  parameter int STD_BASE = 4,
  parameter int RED_BASE = 0
) (
  input  logic              mode_reduced,
  input  logic [ADDR_W-1:0] addr,
  output slot_sel_e         sel
);

  int base;
  int off;

  always_comb begin
    base = mode_reduced ? RED_BASE : STD_BASE;
    off  = int'(addr) - base;
    if (off >= 0 && off < WINDOW_SLOTS) begin
      sel = slot_sel_e'(off[1:0]);
    end else begin
      sel = SEL_NONE;
    end
  end

endmodule

// File: rtl/ctr_mod_inc.sv
module ctr_mod_inc #(
  parameter int BLK_W  = 128,
  parameter int LANE_W = 8,
  parameter int MOD_W  = 8
) (
  input  logic [BLK_W-1:0] ctr,
  input  logic [MOD_W-1:0] m_eff,
  output logic [BLK_W-1:0] nxt
);

  localparam int LANES = BLK_W / LANE_W;

  logic [LANES-1:0] lane_en;
  logic [BLK_W-1:0] mask;
  logic [BLK_W-1:0] sum;

  // a lane joins the running field when M reaches past its first bit
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_en[i] = (int'(m_eff) > i * LANE_W);
    assign mask[i*LANE_W +: LANE_W] = {LANE_W{lane_en[i]}};
  end

  assign sum = ctr + BLK_W'(1);
  assign nxt = (ctr & ~mask) | (sum & mask);

endmodule

// File: rtl/ctr_xor_stage.sv
module ctr_xor_stage #(
  parameter int BLK_W = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             valid,
  input  logic [BLK_W-1:0] data,
  input  logic [BLK_W-1:0] ks,
  output logic [BLK_W-1:0] data_out,
  output logic             out_valid
);

  always_ff @(posedge clk) begin
    if (rst) begin
      data_out  <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= valid;
      if (valid) begin
        data_out <= data ^ ks;
      end
    end
  end

endmodule

// File: rtl/ctr_mod_counter.sv
module ctr_mod_counter
  import ctr_pkg::*;
#(
  parameter int BLK_W    = 128,
  parameter int LANE_W   = 8,
  parameter int MOD_W    = 8,
  parameter int ADDR_W   = 3,
  parameter int STD_BASE = 4,
  parameter int RED_BASE = 0,
  localparam int SLOT_W  = BLK_W / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_reduced,
  input  logic              ctx_wr_en,
  input  logic [ADDR_W-1:0] ctx_wr_addr,
  input  logic [SLOT_W-1:0] ctx_wr_data,
  input  logic [ADDR_W-1:0] ctx_rd_addr,
  output logic [SLOT_W-1:0] ctx_rd_data,
  input  logic              blk_valid,
  input  logic [BLK_W-1:0]  data_in,
  input  logic [BLK_W-1:0]  keystream,
  output logic [BLK_W-1:0]  data_out,
  output logic              out_valid,
  output logic [BLK_W-1:0]  ctr_out
);

  localparam logic [MOD_W-1:0] M_FULL = MOD_W'(BLK_W);

  logic [BLK_W-1:0] ctr_q;
  logic [BLK_W-1:0] ctr_nxt;
  logic [MOD_W-1:0] m_eff;
  slot_sel_e        wr_sel;
  slot_sel_e        rd_sel;
  logic             wr_hi;
  logic             wr_lo;
  logic             wr_mod;

  function automatic logic [MOD_W-1:0] norm_m(input logic [MOD_W-1:0] raw);
    if (raw != '0 && (int'(raw) % LANE_W) == 0 && int'(raw) <= BLK_W) begin
      return raw;
    end
    return M_FULL;
  endfunction

  ctr_ctx_map #(.ADDR_W(ADDR_W), .STD_BASE(STD_BASE), .RED_BASE(RED_BASE)) u_wr_map (
    .mode_reduced (mode_reduced),
    .addr         (ctx_wr_addr),
    .sel          (wr_sel)
  );

  ctr_ctx_map #(.ADDR_W(ADDR_W), .STD_BASE(STD_BASE), .RED_BASE(RED_BASE)) u_rd_map (
    .mode_reduced (mode_reduced),
    .addr         (ctx_rd_addr),
    .sel          (rd_sel)
  );

  ctr_mod_inc #(.BLK_W(BLK_W), .LANE_W(LANE_W), .MOD_W(MOD_W)) u_inc (
    .ctr   (ctr_q),
    .m_eff (m_eff),
    .nxt   (ctr_nxt)
  );

  ctr_xor_stage #(.BLK_W(BLK_W)) u_xor (
    .clk       (clk),
    .rst       (rst),
    .valid     (blk_valid),
    .data      (data_in),
    .ks        (keystream),
    .data_out  (data_out),
    .out_valid (out_valid)
  );

  assign wr_hi  = ctx_wr_en && (wr_sel == SEL_CTR_HI);
  assign wr_lo  = ctx_wr_en && (wr_sel == SEL_CTR_LO);
  assign wr_mod = ctx_wr_en && (wr_sel == SEL_MOD);

  // host counter write has priority over the per-block step
  always_ff @(posedge clk) begin
    if (rst) begin
      ctr_q <= '0;
      m_eff <= M_FULL;
    end else begin
      if (wr_hi || wr_lo) begin
        if (wr_hi) ctr_q[BLK_W-1:SLOT_W] <= ctx_wr_data;
        if (wr_lo) ctr_q[SLOT_W-1:0]     <= ctx_wr_data;
      end else if (blk_valid) begin
        ctr_q <= ctr_nxt;
      end
      if (wr_mod) begin
        m_eff <= norm_m(ctx_wr_data[MOD_W-1:0]);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctx_rd_data <= '0;
    end else begin
      unique case (rd_sel)
        SEL_CTR_HI: ctx_rd_data <= ctr_q[BLK_W-1:SLOT_W];
        SEL_CTR_LO: ctx_rd_data <= ctr_q[SLOT_W-1:0];
        SEL_MOD:    ctx_rd_data <= {{(SLOT_W-MOD_W){1'b0}}, m_eff};
        default:    ctx_rd_data <= '0;
      endcase
    end
  end

  assign ctr_out = ctr_q;

endmodule

// File: rtl/ctr_mod_counter_chk.sv
module ctr_mod_counter_chk #(
  parameter int BLK_W    = 128,
  parameter int LANE_W   = 8,
  parameter int MOD_W    = 8,
  parameter int ADDR_W   = 3,
  parameter int STD_BASE = 4,
  parameter int RED_BASE = 0
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 mode_reduced,
  input logic                 ctx_wr_en,
  input logic [ADDR_W-1:0]    ctx_rd_addr,
  input logic [BLK_W/2-1:0]   ctx_rd_data,
  input logic                 blk_valid,
  input logic [BLK_W-1:0]     data_in,
  input logic [BLK_W-1:0]     keystream,
  input logic [BLK_W-1:0]     data_out,
  input logic                 out_valid,
  input logic [BLK_W-1:0]     ctr_out,
  input logic [MOD_W-1:0]     m_eff
);

  logic [BLK_W-1:0] run_mask;
  logic             rd_outside;
  int               rd_base;

  assign run_mask   = (BLK_W'(1) << m_eff) - BLK_W'(1);
  assign rd_base    = mode_reduced ? RED_BASE : STD_BASE;
  assign rd_outside = (int'(ctx_rd_addr) < rd_base) || (int'(ctx_rd_addr) > rd_base + 2);

  p_valid_follows_r2: assert property (@(posedge clk) disable iff (rst)
    blk_valid |=> out_valid);

  p_valid_drops_r2: assert property (@(posedge clk) disable iff (rst)
    !blk_valid |=> !out_valid);

  p_xor_result_r2: assert property (@(posedge clk) disable iff (rst)
    blk_valid |=> data_out == ($past(data_in) ^ $past(keystream)));

  p_low_step_r3: assert property (@(posedge clk) disable iff (rst)
    (blk_valid && !ctx_wr_en) |=>
      ((ctr_out & $past(run_mask)) == (($past(ctr_out) + BLK_W'(1)) & $past(run_mask))));

  p_upper_fixed_r4: assert property (@(posedge clk) disable iff (rst)
    (blk_valid && !ctx_wr_en) |=> (((ctr_out ^ $past(ctr_out)) & ~$past(run_mask)) == '0));

  p_mod_legal_r5: assert property (@(posedge clk) disable iff (rst)
    (m_eff != '0) && ((int'(m_eff) % LANE_W) == 0) && (int'(m_eff) <= BLK_W));

  p_outside_zero_r7: assert property (@(posedge clk) disable iff (rst)
    rd_outside |=> ctx_rd_data == '0);

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (!blk_valid && !ctx_wr_en) |=> ($stable(ctr_out) && $stable(data_out)));

endmodule

bind ctr_mod_counter ctr_mod_counter_chk #(
  .BLK_W(BLK_W), .LANE_W(LANE_W), .MOD_W(MOD_W),
  .ADDR_W(ADDR_W), .STD_BASE(STD_BASE), .RED_BASE(RED_BASE)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .mode_reduced (mode_reduced),
  .ctx_wr_en    (ctx_wr_en),
  .ctx_rd_addr  (ctx_rd_addr),
  .ctx_rd_data  (ctx_rd_data),
  .blk_valid    (blk_valid),
  .data_in      (data_in),
  .keystream    (keystream),
  .data_out     (data_out),
  .out_valid    (out_valid),
  .ctr_out      (ctr_out),
  .m_eff        (m_eff)
);

// File: tb/sim_ctr_mod_counter.sv
`timescale 1ns/1ps
module sim_ctr_mod_counter;

  logic         clk = 1'b0;
  logic         rst;
  logic         mode_reduced;
  logic         ctx_wr_en;
  logic [2:0]   ctx_wr_addr;
  logic [63:0]  ctx_wr_data;
  logic [2:0]   ctx_rd_addr;
  logic [63:0]  ctx_rd_data;
  logic         blk_valid;
  logic [127:0] data_in;
  logic [127:0] keystream;
  logic [127:0] data_out;
  logic         out_valid;
  logic [127:0] ctr_out;

  int n_total = 0;
  int n_fail  = 0;

  localparam logic [127:0] PAT = 128'hA5A5_5A5A_0F0F_F0F0_3C3C_C3C3_9696_6969;

  always #10 clk = ~clk;

  ctr_mod_counter u0 (
    .clk(clk), .rst(rst), .mode_reduced(mode_reduced),
    .ctx_wr_en(ctx_wr_en), .ctx_wr_addr(ctx_wr_addr), .ctx_wr_data(ctx_wr_data),
    .ctx_rd_addr(ctx_rd_addr), .ctx_rd_data(ctx_rd_data),
    .blk_valid(blk_valid), .data_in(data_in), .keystream(keystream),
    .data_out(data_out), .out_valid(out_valid), .ctr_out(ctr_out)
  );

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_total++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] low_mask(input int m);
    return (128'd1 << m) - 128'd1;
  endfunction

  function automatic logic [127:0] model_step(input logic [127:0] c, input int m);
    logic [127:0] mk;
    mk = low_mask(m);
    return (c & ~mk) | ((c + 128'd1) & mk);
  endfunction

  task automatic wr(input logic [2:0] a, input logic [63:0] d);
    @(negedge clk);
    ctx_wr_en = 1'b1; ctx_wr_addr = a; ctx_wr_data = d;
    @(negedge clk);
    ctx_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [63:0] v);
    @(negedge clk);
    ctx_rd_addr = a;
    @(negedge clk);
    v = ctx_rd_data;
  endtask

  task automatic blk(input logic [127:0] d, input logic [127:0] k);
    @(negedge clk);
    blk_valid = 1'b1; data_in = d; keystream = k;
    @(negedge clk);
    blk_valid = 1'b0;
  endtask

  task automatic load_ctr(input logic [2:0] base, input logic [127:0] c);
    wr(base, c[127:64]);
    wr(base + 3'd1, c[63:0]);
  endtask

  initial begin
    #(20 * 200000);
    n_total++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

  initial begin
    logic [63:0]  v;
    logic [127:0] c;
    rst = 1'b1; mode_reduced = 1'b0; ctx_wr_en = 1'b0; ctx_wr_addr = '0;
    ctx_wr_data = '0; ctx_rd_addr = 3'd6; blk_valid = 1'b0; data_in = '0; keystream = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 ctr", ctr_out, '0);
    check("R1 out_valid", {127'd0, out_valid}, 128'd0);
    check("R1 data_out", data_out, '0);
    rd(3'd6, v);
    check("R1 M=128", {64'd0, v}, 128'd128);

    // R6 standard window load and readback, R8
    load_ctr(3'd4, PAT);
    check("R6 ctr load std", ctr_out, PAT);
    rd(3'd4, v); check("R6 R8 hi slot", {64'd0, v}, {64'd0, PAT[127:64]});
    rd(3'd5, v); check("R6 R8 lo slot", {64'd0, v}, {64'd0, PAT[63:0]});

    // R2 XOR with several patterns
    c = ctr_out;
    blk('0, '0);
    check("R2 zero xor", data_out, '0);
    check("R2 valid", {127'd0, out_valid}, 128'd1);
    check("R3 step M=128", ctr_out, c + 128'd1);
    blk({4{32'hAAAA_AAAA}}, {4{32'h5555_5555}});
    check("R2 alt xor", data_out, '1);
    blk(PAT, 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210);
    check("R2 mixed xor", data_out, PAT ^ 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210);
    @(negedge clk);
    check("R2 valid drop", {127'd0, out_valid}, 128'd0);

    // R10 idle hold
    c = ctr_out;
    repeat (3) @(negedge clk);
    check("R10 ctr hold", ctr_out, c);
    check("R10 data hold", data_out, PAT ^ 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210);

    // R3 R4 R5 sweep over every legal M
    for (int m = 8; m <= 128; m += 8) begin
      logic [127:0] mk;
      logic [127:0] start;
      mk = low_mask(m);
      start = PAT | mk;
      wr(3'd6, 64'(m));
      load_ctr(3'd4, start);
      rd(3'd6, v);
      check($sformatf("R5 M readback %0d", m), {64'd0, v}, 128'(m));
      blk('0, '0);
      check($sformatf("R4 wrap M=%0d", m), ctr_out, model_step(start, m));
      check($sformatf("R4 upper kept M=%0d", m), ctr_out, PAT & ~mk);
      blk('0, '0);
      check($sformatf("R3 step after wrap M=%0d", m), ctr_out, (PAT & ~mk) | 128'd1);
    end

    // R5 illegal exponents fall back to 128
    wr(3'd6, 64'd12);
    rd(3'd6, v); check("R5 illegal 12", {64'd0, v}, 128'd128);
    wr(3'd6, 64'd16);
    wr(3'd6, 64'd0);
    rd(3'd6, v); check("R5 illegal 0", {64'd0, v}, 128'd128);
    wr(3'd6, 64'd200);
    rd(3'd6, v); check("R5 illegal 200", {64'd0, v}, 128'd128);
    load_ctr(3'd4, '1);
    blk('0, '0);
    check("R5 full wrap", ctr_out, '0);

    // R6 R7 reduced window
    mode_reduced = 1'b1;
    load_ctr(3'd0, ~PAT);
    check("R6 reduced load", ctr_out, ~PAT);
    wr(3'd2, 64'd32);
    rd(3'd2, v); check("R6 reduced M", {64'd0, v}, 128'd32);
    rd(3'd0, v); check("R6 reduced hi", {64'd0, v}, {64'd0, ~PAT[127:64]});
    wr(3'd4, 64'h1111_2222_3333_4444);
    wr(3'd5, 64'h5555_6666_7777_8888);
    wr(3'd6, 64'd8);
    check("R7 ignored write ctr", ctr_out, ~PAT);
    rd(3'd2, v); check("R7 ignored write M", {64'd0, v}, 128'd32);
    rd(3'd4, v); check("R7 outside read", {64'd0, v}, '0);
    mode_reduced = 1'b0;
    rd(3'd1, v); check("R7 outside read std", {64'd0, v}, '0);
    rd(3'd4, v); check("R6 std hi again", {64'd0, v}, {64'd0, ~PAT[127:64]});

    // R9 write collides with a block
    c = ctr_out;
    @(negedge clk);
    blk_valid = 1'b1; data_in = PAT; keystream = '0;
    ctx_wr_en = 1'b1; ctx_wr_addr = 3'd5; ctx_wr_data = 64'hDEAD_BEEF_0000_0001;
    @(negedge clk);
    blk_valid = 1'b0; ctx_wr_en = 1'b0;
    check("R9 write wins", ctr_out, {c[127:64], 64'hDEAD_BEEF_0000_0001});
    check("R9 output still made", data_out, PAT);

    // R8 read during streaming
    @(negedge clk);
    blk_valid = 1'b1; ctx_rd_addr = 3'd5;
    @(negedge clk);
    blk_valid = 1'b0;
    check("R8 read pre-edge value", {64'd0, ctx_rd_data}, {64'd0, 64'hDEAD_BEEF_0000_0001});
    @(negedge clk);
    check("R8 read post-step", {64'd0, ctx_rd_data}, {64'd0, 64'hDEAD_BEEF_0000_0002});

    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

endmodule